// File: doc/BRIEF.md
# Instruction Shelf with Associative Renaming

The shelf is the in-flight instruction window of an out-of-order core, kept as one circular queue that plays three roles at once: the rename table, the operand waiting station and the reorder buffer. Every instruction placed in the window receives one slot. The index of that slot is its tag, and the tag is how later instructions name its result. Source registers are renamed without a map table. Each slot remembers its destination register and carries a flag that marks it as the most recent writer of that register. A new instruction looks up its sources by an associative compare against those flags.

Each cycle the block accepts one new instruction at the head, one result from a functional unit addressed by tag, and one retirement from the tail. On retirement the oldest slot's result is written into a 32-entry architectural register file. A flush request names an offending slot. It discards every younger slot and keeps the offending slot and everything older. A read port resolves the two operands of any slot, taking the value from the producing slot if that slot is still in flight and from the register file otherwise. The dispatch picker and the functional units sit outside the block and use this port.

Top module: `rename_shelf`

## Requirements
- R1: After reset the window is empty: `issueReady`=1, `retireValid`=0, and every architectural register reads as 0 through a source that was not renamed.
- R2: Accepted instructions receive tags equal to the head index, which advances by one modulo the depth (8). With 8 slots occupied `issueReady` is 0 and an issue request is dropped; no slot is created.
- R3: A source is renamed to the youngest in-flight slot that writes the same register. If there is none, it reads the architectural register file. Older writers of the same register are not chosen.
- R4: A renamed source is locked (lock output 1) while its producer has not delivered a result. A result update writes the producer's data, marks it executed and unlocks every source tagged with it; the operand value then equals that data.
- R5: When a result update for tag T and an issue whose source renames to T happen in the same cycle, the new source is unlocked and reads the updated data.
- R6: Retirement is strictly from the oldest slot, one per cycle, and only once that slot has executed. `retireValid`, `retireDst` and `retireData` show the retiring slot, and the register file is written with its data.
- R7: After a producer retires, sources already renamed to it read the same value from the register file, and new instructions reading that register fall back to the register file.
- R8: A flush naming an in-flight tag F discards all slots younger than F and keeps F and the older slots. The next issued tag is F+1. An issue request in the flush cycle is dropped.
- R9: After a flush, renaming selects the youngest surviving writer of a register. If no writer survives, the source reads the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request |
| issueDst | input | 5 | Destination register of the issued instruction |
| issueSrcA | input | 5 | First source register |
| issueSrcB | input | 5 | Second source register |
| issueReady | output | 1 | A free slot exists |
| issueTag | output | 3 | Tag the next accepted instruction receives |
| updValid | input | 1 | Result update strobe |
| updTag | input | 3 | Tag of the producing slot |
| updData | input | 32 | Result value |
| flushValid | input | 1 | Discard request |
| flushTag | input | 3 | Offending slot; younger slots are dropped |
| retireValid | output | 1 | Oldest slot retires this cycle |
| retireDst | output | 5 | Register written by the retiring slot |
| retireData | output | 32 | Value written by the retiring slot |
| peekTag | input | 3 | Slot whose operands are read |
| peekActive | output | 1 | That slot is in flight |
| peekLockA | output | 1 | First operand still waits |
| peekLockB | output | 1 | Second operand still waits |
| peekValA | output | 32 | Resolved first operand |
| peekValB | output | 32 | Resolved second operand |

## Verification
The hardest states to reach are where the latest-writer flags and the register file must agree across an event that changes both. Three cases fall here: a flush that removes the current latest writer of a register while an older writer survives; a producer retiring while a consumer still points at its tag; and a result arriving in the same cycle as a dependent issue. The stimulus reaches these states by holding back the oldest slot's result, so nothing retires, while younger writers of one register pile up. It then delivers results youngest first and flushes or releases the oldest slot on purpose, so that each rename, lock and retire moment falls on a known cycle.

// File: rtl/rename_shelf_pkg.sv
package rename_shelf_pkg;

  // Per-cycle actions decided by the control and carried out by the datapath.
  typedef struct packed {
    logic issueEn;
    logic updEn;
    logic retireEn;
    logic flushEn;
  } shelf_strobe_t;

endpackage

// File: rtl/rename_shelf_ctrl.sv
module rename_shelf_ctrl
  import rename_shelf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             updValid,
  input  logic [IDW-1:0]   updTag,
  input  logic             flushValid,
  input  logic [IDW-1:0]   flushTag,
  input  logic             tailExecuted,
  output shelf_strobe_t    strobe,
  output logic [IDW-1:0]   headPtr,
  output logic [IDW-1:0]   tailPtr,
  output logic [DEPTH-1:0] activeMask,
  output logic [DEPTH-1:0] keepMask,
  output logic             issueReady
);

  localparam logic [IDW:0] FULL = (IDW+1)'(DEPTH);

  logic [IDW:0] count;
  logic [IDW:0] countNext;

  function automatic logic [IDW-1:0] ageOf(input logic [IDW-1:0] idx,
                                           input logic [IDW-1:0] base);
    return idx - base;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_mask
    assign activeMask[i] = {1'b0, ageOf(IDW'(i), tailPtr)} < count;
    assign keepMask[i]   = activeMask[i] &&
                           (ageOf(IDW'(i), tailPtr) <= ageOf(flushTag, tailPtr));
  end

  assign issueReady = (count != FULL);

  always_comb begin
    strobe.flushEn  = flushValid && activeMask[flushTag];
    strobe.updEn    = updValid && activeMask[updTag];
    strobe.retireEn = (count != '0) && tailExecuted;
    strobe.issueEn  = issueValid && issueReady && !flushValid;
  end

  always_comb begin
    countNext = count;
    if (strobe.flushEn) countNext = {1'b0, ageOf(flushTag, tailPtr)} + 1'b1;
    else if (strobe.issueEn) countNext = count + 1'b1;
    if (strobe.retireEn) countNext = countNext - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      count <= countNext;
      if (strobe.retireEn) tailPtr <= tailPtr + 1'b1;
      if (strobe.flushEn) headPtr <= flushTag + 1'b1;
      else if (strobe.issueEn) headPtr <= headPtr + 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL && !strobe.retireEn && !strobe.flushEn) |=> (count == FULL)); // R2
  AST_FLUSH_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushEn |=> (headPtr == $past(flushTag) + 1'b1)); // R8

endmodule

// File: rtl/rename_shelf_dp.sv
module rename_shelf_dp
  import rename_shelf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  localparam int IDW = $clog2(DEPTH),
  localparam int RW  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  shelf_strobe_t    strobe,
  input  logic [IDW-1:0]   headPtr,
  input  logic [IDW-1:0]   tailPtr,
  input  logic [DEPTH-1:0] activeMask,
  input  logic [DEPTH-1:0] keepMask,
  input  logic [RW-1:0]    issueDst,
  input  logic [RW-1:0]    issueSrcA,
  input  logic [RW-1:0]    issueSrcB,
  input  logic [IDW-1:0]   updTag,
  input  logic [XLEN-1:0]  updData,
  input  logic [IDW-1:0]   peekTag,
  output logic             tailExecuted,
  output logic [RW-1:0]    retireDst,
  output logic [XLEN-1:0]  retireData,
  output logic             peekActive,
  output logic             peekLockA,
  output logic             peekLockB,
  output logic [XLEN-1:0]  peekValA,
  output logic [XLEN-1:0]  peekValB
);

  // Slot storage
  logic [RW-1:0]    dst     [DEPTH];
  logic [XLEN-1:0]  data    [DEPTH];
  logic [DEPTH-1:0] latest;
  logic [DEPTH-1:0] executed;
  logic [RW-1:0]    srcReg  [2][DEPTH];
  logic [IDW-1:0]   srcTag  [2][DEPTH];
  logic [DEPTH-1:0] srcRen  [2];
  logic [DEPTH-1:0] srcLock [2];
  // Architectural register file
  logic [XLEN-1:0]  arf     [NREG];

  logic [RW-1:0]    issueSrc [2];
  logic [1:0]       hit;
  logic [IDW-1:0]   hitTag  [2];
  logic [1:0]       hitLock;
  logic [DEPTH-1:0] keepLatest;

  function automatic logic [IDW-1:0] ageOf(input logic [IDW-1:0] idx,
                                           input logic [IDW-1:0] base);
    return idx - base;
  endfunction

  assign issueSrc[0] = issueSrcA;
  assign issueSrc[1] = issueSrcB;

  // Associative source lookup over in-flight latest writers.
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      hit[s]    = 1'b0;
      hitTag[s] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (activeMask[i] && latest[i] && dst[i] == issueSrc[s] &&
            !(strobe.retireEn && IDW'(i) == tailPtr)) begin
          hit[s]    = 1'b1;
          hitTag[s] = IDW'(i);
        end
      end
      hitLock[s] = hit[s] && !executed[hitTag[s]] &&
                   !(strobe.updEn && updTag == hitTag[s]);
    end
  end

  // Latest flags rebuilt over the surviving slots of a flush.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      keepLatest[i] = keepMask[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (keepMask[j] && dst[j] == dst[i] &&
            ageOf(IDW'(j), tailPtr) > ageOf(IDW'(i), tailPtr))
          keepLatest[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latest   <= '0;
      executed <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        dst[i]  <= '0;
        data[i] <= '0;
      end
      for (int s = 0; s < 2; s++) begin
        srcRen[s]  <= '0;
        srcLock[s] <= '0;
        for (int i = 0; i < DEPTH; i++) begin
          srcReg[s][i] <= '0;
          srcTag[s][i] <= '0;
        end
      end
      for (int r = 0; r < NREG; r++) arf[r] <= '0;
    end else begin
      if (strobe.updEn) begin
        data[updTag]     <= updData;
        executed[updTag] <= 1'b1;
      end
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (strobe.updEn && srcRen[s][i] && srcTag[s][i] == updTag)
            srcLock[s][i] <= 1'b0;
          if (strobe.retireEn && srcRen[s][i] && srcTag[s][i] == tailPtr) begin
            srcRen[s][i]  <= 1'b0;
            srcLock[s][i] <= 1'b0;
          end
        end
      end
      if (strobe.retireEn) arf[dst[tailPtr]] <= data[tailPtr];
      if (strobe.issueEn) begin
        for (int i = 0; i < DEPTH; i++)
          if (activeMask[i] && dst[i] == issueDst) latest[i] <= 1'b0;
        dst[headPtr]      <= issueDst;
        latest[headPtr]   <= 1'b1;
        executed[headPtr] <= 1'b0;
        for (int s = 0; s < 2; s++) begin
          srcReg[s][headPtr]  <= issueSrc[s];
          srcRen[s][headPtr]  <= hit[s];
          srcTag[s][headPtr]  <= hitTag[s];
          srcLock[s][headPtr] <= hitLock[s];
        end
      end
      if (strobe.flushEn) latest <= keepLatest;
    end
  end

  assign tailExecuted = executed[tailPtr];
  assign retireDst    = dst[tailPtr];
  assign retireData   = data[tailPtr];

  // Operand read: in-flight producer data, else architectural value.
  assign peekActive = activeMask[peekTag];
  assign peekLockA  = srcLock[0][peekTag];
  assign peekLockB  = srcLock[1][peekTag];
  assign peekValA   = srcRen[0][peekTag] ? data[srcTag[0][peekTag]]
                                         : arf[srcReg[0][peekTag]];
  assign peekValB   = srcRen[1][peekTag] ? data[srcTag[1][peekTag]]
                                         : arf[srcReg[1][peekTag]];

  AST_RETIRE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.retireEn |-> activeMask[tailPtr]); // R6
  AST_UPD_EXECUTES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updEn |=> executed[$past(updTag)]); // R4

  for (genvar s = 0; s < 2; s++) begin : g_chkSrc
    for (genvar i = 0; i < DEPTH; i++) begin : g_chkSlot
      AST_LOCK_PENDING: assert property (@(posedge clk) disable iff (!rstN)
        (activeMask[i] && srcLock[s][i]) |->
          (srcRen[s][i] && activeMask[srcTag[s][i]] && !executed[srcTag[s][i]])); // R4
    end
  end

endmodule

// File: rtl/rename_shelf.sv
module rename_shelf
  import rename_shelf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int XLEN  = 32,
  localparam int IDW = $clog2(DEPTH),
  localparam int RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            issueValid,
  input  logic [RW-1:0]   issueDst,
  input  logic [RW-1:0]   issueSrcA,
  input  logic [RW-1:0]   issueSrcB,
  output logic            issueReady,
  output logic [IDW-1:0]  issueTag,
  input  logic            updValid,
  input  logic [IDW-1:0]  updTag,
  input  logic [XLEN-1:0] updData,
  input  logic            flushValid,
  input  logic [IDW-1:0]  flushTag,
  output logic            retireValid,
  output logic [RW-1:0]   retireDst,
  output logic [XLEN-1:0] retireData,
  input  logic [IDW-1:0]  peekTag,
  output logic            peekActive,
  output logic            peekLockA,
  output logic            peekLockB,
  output logic [XLEN-1:0] peekValA,
  output logic [XLEN-1:0] peekValB
);

  shelf_strobe_t    strobe;
  logic [IDW-1:0]   headPtr;
  logic [IDW-1:0]   tailPtr;
  logic [DEPTH-1:0] activeMask;
  logic [DEPTH-1:0] keepMask;
  logic             tailExecuted;

  rename_shelf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid),
    .updValid(updValid), .updTag(updTag),
    .flushValid(flushValid), .flushTag(flushTag),
    .tailExecuted(tailExecuted), .strobe(strobe),
    .headPtr(headPtr), .tailPtr(tailPtr),
    .activeMask(activeMask), .keepMask(keepMask), .issueReady(issueReady)
  );

  rename_shelf_dp #(.DEPTH(DEPTH), .NREG(NREG), .XLEN(XLEN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headPtr(headPtr), .tailPtr(tailPtr),
    .activeMask(activeMask), .keepMask(keepMask),
    .issueDst(issueDst), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .updTag(updTag), .updData(updData), .peekTag(peekTag),
    .tailExecuted(tailExecuted), .retireDst(retireDst), .retireData(retireData),
    .peekActive(peekActive), .peekLockA(peekLockA), .peekLockB(peekLockB),
    .peekValA(peekValA), .peekValB(peekValB)
  );

  assign issueTag    = headPtr;
  assign retireValid = strobe.retireEn;

endmodule

// File: tb/rename_shelf_bench.sv
`timescale 1ns/1ps
module rename_shelf_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [4:0]  issueDst, issueSrcA, issueSrcB;
  logic        issueReady;
  logic [2:0]  issueTag;
  logic        updValid;
  logic [2:0]  updTag;
  logic [31:0] updData;
  logic        flushValid;
  logic [2:0]  flushTag;
  logic        retireValid;
  logic [4:0]  retireDst;
  logic [31:0] retireData;
  logic [2:0]  peekTag;
  logic        peekActive, peekLockA, peekLockB;
  logic [31:0] peekValA, peekValB;

  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;
  logic [2:0] expHead = '0;

  always #4 clk = ~clk;

  rename_shelf u_rename_shelf (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueReady(issueReady),
    .issueTag(issueTag), .updValid(updValid), .updTag(updTag), .updData(updData),
    .flushValid(flushValid), .flushTag(flushTag), .retireValid(retireValid),
    .retireDst(retireDst), .retireData(retireData), .peekTag(peekTag),
    .peekActive(peekActive), .peekLockA(peekLockA), .peekLockB(peekLockB),
    .peekValA(peekValA), .peekValB(peekValB)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
    chk("R2 ready", issueReady, 1);
    chk("R2 tag", issueTag, expHead);
    issueValid = 1'b1; issueDst = d; issueSrcA = a; issueSrcB = b;
    @(negedge clk);
    issueValid = 1'b0;
    expHead = expHead + 1'b1;
  endtask

  task automatic update(input logic [2:0] t, input logic [31:0] v);
    updValid = 1'b1; updTag = t; updData = v;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic peek(input logic [2:0] t);
    peekTag = t;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; issueValid = 0; issueDst = 0; issueSrcA = 0; issueSrcB = 0;
    updValid = 0; updTag = 0; updData = 0; flushValid = 0; flushTag = 0; peekTag = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready", issueReady, 1);
    chk("R1 retire", retireValid, 0);

    // Fill: slot k writes r(k+1) and reads r(k) and r20.
    for (int k = 0; k < 8; k++) issue(5'(k + 1), 5'(k), 5'd20);
    for (int k = 0; k < 8; k++) begin
      peek(3'(k));
      chk("R4 lock on pending producer", peekLockA, (k > 0) ? 1 : 0);
      chk("R1 arf zero", peekValB, 0);
      chk("R1 no lock", peekLockB, 0);
      if (k == 0) chk("R1 arf zero A", peekValA, 0);
    end
    chk("R2 full", issueReady, 0);
    issueValid = 1'b1; issueDst = 5'd25; issueSrcA = 0; issueSrcB = 0;
    @(negedge clk);
    issueValid = 1'b0;

    // Results youngest first; nothing retires until slot 0 executes.
    for (int j = 7; j >= 1; j--) begin
      update(3'(j), 32'(100 + j));
      if (j < 7) begin
        peek(3'(j + 1));
        chk("R4 unlock", peekLockA, 0);
        chk("R4 value", peekValA, 32'(100 + j));
      end
      chk("R6 oldest pending", retireValid, 0);
    end
    update(3'd0, 32'd100);
    for (int k = 0; k < 8; k++) begin
      chk("R6 retire valid", retireValid, 1);
      chk("R6 retire dst", retireDst, 32'(k + 1));
      chk("R6 retire data", retireData, 32'(100 + k));
      if (k >= 1) begin
        peek(3'(k));
        chk("R7 retired producer value", peekValA, 32'(100 + k - 1));
        chk("R7 retired producer lock", peekLockA, 0);
      end
      @(negedge clk);
    end
    chk("R2 dropped issue", retireValid, 0);
    chk("R2 empty ready", issueReady, 1);

    // New readers fall back to the register file.
    for (int k = 0; k < 8; k++) issue(5'd31, 5'(k + 1), 5'd0);
    for (int k = 0; k < 8; k++) begin
      peek(3'(k));
      chk("R7 arf fallback", peekValA, 32'(100 + k));
      chk("R7 arf no lock", peekLockA, 0);
    end
    flushValid = 1'b1; flushTag = 3'd0;
    issueValid = 1'b1; issueDst = 5'd2; issueSrcA = 0; issueSrcB = 0;
    @(negedge clk);
    flushValid = 1'b0; issueValid = 1'b0;
    expHead = 3'd1;
    chk("R8 head after flush", issueTag, 1);
    chk("R8 survivors", retireValid, 0);
    peek(3'd1);
    chk("R8 discarded slot", peekActive, 0);
    update(3'd0, 32'd7);
    chk("R6 survivor retires", retireValid, 1);
    chk("R6 survivor dst", retireDst, 31);
    @(negedge clk);

    // Flush removes the latest writer of r3; r4 writer is discarded.
    issue(5'd3, 5'd0, 5'd0);   // tag 1
    issue(5'd3, 5'd0, 5'd0);   // tag 2
    issue(5'd3, 5'd0, 5'd0);   // tag 3
    issue(5'd4, 5'd0, 5'd0);   // tag 4
    flushValid = 1'b1; flushTag = 3'd2;
    issueValid = 1'b1; issueDst = 5'd9; issueSrcA = 5'd3; issueSrcB = 0;
    @(negedge clk);
    flushValid = 1'b0; issueValid = 1'b0;
    expHead = 3'd3;
    issue(5'd13, 5'd3, 5'd4);  // tag 3
    peek(3'd3);
    chk("R9 renamed to survivor", peekLockA, 1);
    chk("R9 discarded writer gone", peekLockB, 0);
    chk("R9 arf value", peekValB, 103);
    update(3'd2, 32'h55);
    peek(3'd3);
    chk("R3 youngest writer value", peekValA, 32'h55);
    chk("R3 unlocked", peekLockA, 0);
    update(3'd1, 32'h44);
    peek(3'd3);
    chk("R3 older writer ignored", peekValA, 32'h55);
    chk("R6 order first", retireData, 32'h44);
    @(negedge clk);
    chk("R6 order second", retireData, 32'h55);
    @(negedge clk);
    chk("R6 wait for result", retireValid, 0);
    update(3'd3, 32'h66);
    chk("R6 consumer retires", retireDst, 13);
    @(negedge clk);

    // Same-cycle result and dependent issue.
    issue(5'd9, 5'd0, 5'd0);   // tag 4
    chk("R2 tag before combo", issueTag, 5);
    updValid = 1'b1; updTag = 3'd4; updData = 32'h99;
    issueValid = 1'b1; issueDst = 5'd14; issueSrcA = 5'd9; issueSrcB = 5'd9;
    @(negedge clk);
    updValid = 1'b0; issueValid = 1'b0;
    expHead = 3'd6;
    peek(3'd5);
    chk("R5 lock A", peekLockA, 0);
    chk("R5 lock B", peekLockB, 0);
    chk("R5 value", peekValA, 32'h99);
    @(negedge clk);
    update(3'd5, 32'h1);
    @(negedge clk);
    chk("R6 drained", retireValid, 0);

    // Sweep: n writers of r12, one reader.
    for (int n = 1; n <= 4; n++) begin
      logic [2:0] base;
      logic [2:0] cons;
      int seen;
      base = expHead;
      for (int k = 0; k < n; k++) issue(5'd12, 5'd0, 5'd0);
      cons = expHead;
      issue(5'd13, 5'd12, 5'd0);
      peek(cons);
      chk("R4 sweep locked", peekLockA, 1);
      for (int k = n - 1; k >= 1; k--) update(base + 3'(k), 32'(4096 + n * 16 + k));
      update(cons, 32'd0);
      if (n > 1) begin
        peek(cons);
        chk("R3 sweep value", peekValA, 32'(4096 + n * 16 + n - 1));
        chk("R3 sweep lock", peekLockA, 0);
      end
      update(base, 32'(4096 + n * 16));
      peek(cons);
      chk("R3 sweep final", peekValA, 32'(4096 + n * 16 + n - 1));
      seen = 0;
      for (int w = 0; w < 12; w++) begin
        if (retireValid) begin
          chk("R6 sweep dst", retireDst, (seen < n) ? 12 : 13);
          seen++;
        end
        @(negedge clk);
      end
      chk("R6 sweep count", seen, n + 1);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

endmodule